// File: doc/BRIEF.md
# Two-Wire Slave Byte Buffers

This block sits between a CPU and the shift engine of a two-wire bus slave. It holds two independent byte queues. The receive queue collects bytes the bus master has written until software reads them. The transmit queue holds bytes that software has prepared until the master reads them. Both queues are eight bytes deep by default.

Software reaches both queues through one data register. A read of that register takes the oldest byte from the receive queue. A write to it appends a byte to the transmit queue.

The shift engine offers a received byte by holding `rx_valid_i`. It asks for a byte to send by holding `tx_req_i`. If the receive queue has no room, or the transmit queue has nothing to send, the block raises `stretch_o`. The engine then holds the bus clock low until the request drops. Each byte that moves across the bus-side boundary produces a single-cycle strobe. The interrupt controller and the engine both use these strobes. The block also provides full and empty levels for the interrupt controller. A bus timeout or an interface reset, signalled on `flush_i`, empties both queues.

Top module: `tws_byte_buf`

## Requirements
- R1: After `rst_ni` is released, both queues are empty (`rx_empty_o`=1, `tx_empty_o`=1, both full flags 0), `stretch_o`=0, `tx_ovf_o`=0 and `cpu_rdata_o`=0x00.
- R2: A byte offered on `rx_data_i` with `rx_valid_i`=1 while the receive queue is not full is stored at the clock edge. Bytes come out in arrival order. `rx_full_o` is 1 once 8 bytes are held.
- R3: `cpu_rdata_o` shows the oldest received byte, and `cpu_rd_i`=1 removes that byte at the edge. When the receive queue is empty, `cpu_rdata_o` is 0x00 and a read changes nothing: the next stored byte is the next one returned.
- R4: `cpu_wr_i`=1 appends `cpu_wdata_i` to the transmit queue. `tx_data_o` shows the oldest queued byte. `tx_full_o` is 1 once 8 bytes are held. Transmit activity does not change the receive queue flags.
- R5: A CPU write while the transmit queue is full is discarded and sets `tx_ovf_o`. The flag stays 1 until `rst_ni` is asserted, and a flush does not clear it.
- R6: While `rx_valid_i`=1 and the receive queue is full, `stretch_o`=1, no byte is stored and `rx_byte_o`=0.
- R7: While `tx_req_i`=1 and the transmit queue is empty, `stretch_o`=1 and `tx_byte_o`=0.
- R8: `stretch_o` drops in the first cycle in which room or data exists. The held transfer completes at the edge that ends that cycle.
- R9: `rx_byte_o` is 1 for exactly the cycles in which a byte enters the receive queue. `tx_byte_o` is 1 for exactly the cycles in which a byte leaves the transmit queue toward the engine. While `tx_byte_o`=1, `tx_data_o` carries that byte.
- R10: `flush_i`=1 at a clock edge empties both queues. No transfer takes place in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Bus timeout or interface reset; empties both queues |
| cpu_wr_i | input | 1 | CPU write to the data register |
| cpu_rd_i | input | 1 | CPU read of the data register |
| cpu_wdata_i | input | 8 | Byte written by the CPU |
| cpu_rdata_o | output | 8 | Oldest received byte, 0x00 when empty |
| rx_valid_i | input | 1 | Shift engine holds a received byte |
| rx_data_i | input | 8 | Received byte from the shift engine |
| rx_byte_o | output | 1 | Strobe: byte entered the receive queue |
| tx_req_i | input | 1 | Shift engine needs a byte to send |
| tx_data_o | output | 8 | Oldest byte of the transmit queue |
| tx_byte_o | output | 1 | Strobe: byte handed to the shift engine |
| stretch_o | output | 1 | Clock-stretch request |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_ovf_o | output | 1 | Sticky: CPU write discarded on a full transmit queue |

## Verification
The strobes, `stretch_o`, `cpu_rdata_o` and `tx_data_o` follow the current inputs and the queue state in the same cycle. The bench therefore samples them in the cycle in which it drives the stimulus, half a period after the inputs change. Queue flags, stored data and `tx_ovf_o` change at the edge that ends the stimulus cycle, so the bench checks them at the falling edge after that. In the stretch scenarios the bench frees room or data in one cycle. It then expects `stretch_o` low and the strobe high in the next cycle, and the queue contents one edge later.

// File: rtl/tws_buf_pkg.sv
package tws_buf_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/tws_byte_fifo.sv
module tws_byte_fifo #(
  parameter int unsigned DEPTH = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                push_i,
  input  tws_buf_pkg::byte_t  data_i,
  input  logic                pop_i,
  output tws_buf_pkg::byte_t  head_o,
  output logic                full_o,
  output logic                empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  tws_buf_pkg::byte_t mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic push_ok, pop_ok;

  assign full_o  = (count == CW'(DEPTH));
  assign empty_o = (count == '0);
  assign push_ok = push_i & ~full_o & ~flush_i;
  assign pop_ok  = pop_i & ~empty_o & ~flush_i;
  assign head_o  = empty_o ? '0 : mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= data_i;
  end
endmodule

// File: rtl/tws_flow_ctl.sv
module tws_flow_ctl (
  input  logic flush_i,
  input  logic rx_valid_i,
  input  logic rx_full_i,
  input  logic tx_req_i,
  input  logic tx_empty_i,
  output logic rx_store_o,
  output logic tx_send_o,
  output logic stretch_o
);
  assign rx_store_o = rx_valid_i & ~rx_full_i & ~flush_i;
  assign tx_send_o  = tx_req_i & ~tx_empty_i & ~flush_i;
  // hold bus while engine would overrun rx or underrun tx
  assign stretch_o  = (rx_valid_i & rx_full_i) | (tx_req_i & tx_empty_i);
endmodule

// File: rtl/tws_byte_buf.sv
module tws_byte_buf #(
  parameter int unsigned RX_DEPTH = 8,
  parameter int unsigned TX_DEPTH = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flush_i,
  input  logic       cpu_wr_i,
  input  logic       cpu_rd_i,
  input  logic [7:0] cpu_wdata_i,
  output logic [7:0] cpu_rdata_o,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       rx_byte_o,
  input  logic       tx_req_i,
  output logic [7:0] tx_data_o,
  output logic       tx_byte_o,
  output logic       stretch_o,
  output logic       rx_full_o,
  output logic       rx_empty_o,
  output logic       tx_full_o,
  output logic       tx_empty_o,
  output logic       tx_ovf_o
);
  logic rx_store, tx_send;

  tws_flow_ctl u_flow (
    .flush_i    (flush_i),
    .rx_valid_i (rx_valid_i),
    .rx_full_i  (rx_full_o),
    .tx_req_i   (tx_req_i),
    .tx_empty_i (tx_empty_o),
    .rx_store_o (rx_store),
    .tx_send_o  (tx_send),
    .stretch_o  (stretch_o)
  );

  tws_byte_fifo #(.DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .push_i  (rx_store),
    .data_i  (rx_data_i),
    .pop_i   (cpu_rd_i),
    .head_o  (cpu_rdata_o),
    .full_o  (rx_full_o),
    .empty_o (rx_empty_o)
  );

  tws_byte_fifo #(.DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .push_i  (cpu_wr_i),
    .data_i  (cpu_wdata_i),
    .pop_i   (tx_send),
    .head_o  (tx_data_o),
    .full_o  (tx_full_o),
    .empty_o (tx_empty_o)
  );

  assign rx_byte_o = rx_store;
  assign tx_byte_o = tx_send;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 tx_ovf_o <= 1'b0;
    else if (cpu_wr_i && tx_full_o && !flush_i)  tx_ovf_o <= 1'b1;
  end
endmodule

// File: rtl/tws_byte_buf_chk.sv
module tws_byte_buf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic flush_i,
  input logic cpu_wr_i,
  input logic cpu_rd_i,
  input logic rx_valid_i,
  input logic rx_byte_o,
  input logic tx_req_i,
  input logic tx_byte_o,
  input logic stretch_o,
  input logic rx_full_o,
  input logic rx_empty_o,
  input logic tx_full_o,
  input logic tx_empty_o,
  input logic tx_ovf_o
);
  // R6
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_full_o) |-> (stretch_o && !rx_byte_o));
  // R7
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_i && tx_empty_o) |-> (stretch_o && !tx_byte_o));
  // R5
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && tx_full_o && !flush_i) |=> tx_ovf_o);
  // R5
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ovf_o |=> tx_ovf_o);
  // R10
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (rx_empty_o && tx_empty_o));
  // R3
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_empty_o && cpu_rd_i && !rx_byte_o) |=> rx_empty_o);
  // R2
  rx_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_full_o && rx_empty_o));
  // R4
  tx_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_full_o && tx_empty_o));
  // R8
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_full_o && !flush_i) |-> rx_byte_o);
endmodule

bind tws_byte_buf tws_byte_buf_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .flush_i    (flush_i),
  .cpu_wr_i   (cpu_wr_i),
  .cpu_rd_i   (cpu_rd_i),
  .rx_valid_i (rx_valid_i),
  .rx_byte_o  (rx_byte_o),
  .tx_req_i   (tx_req_i),
  .tx_byte_o  (tx_byte_o),
  .stretch_o  (stretch_o),
  .rx_full_o  (rx_full_o),
  .rx_empty_o (rx_empty_o),
  .tx_full_o  (tx_full_o),
  .tx_empty_o (tx_empty_o),
  .tx_ovf_o   (tx_ovf_o)
);

// File: tb/tws_byte_buf_test.sv
`timescale 1ns/1ps
module tws_byte_buf_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
  logic [7:0] cpu_wdata = '0, rx_data = '0;
  logic [7:0] cpu_rdata, tx_data;
  logic rx_byte, tx_byte, stretch, rx_full, rx_empty, tx_full, tx_empty, tx_ovf;
  int n_chk = 0, n_fail = 0;
  logic [7:0] got;

  always #5 clk = ~clk;

  tws_byte_buf uut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .cpu_wr_i(cpu_wr), .cpu_rd_i(cpu_rd), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_byte_o(rx_byte),
    .tx_req_i(tx_req), .tx_data_o(tx_data), .tx_byte_o(tx_byte),
    .stretch_o(stretch), .rx_full_o(rx_full), .rx_empty_o(rx_empty),
    .tx_full_o(tx_full), .tx_empty_o(tx_empty), .tx_ovf_o(tx_ovf)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    #1 check("R9 rx strobe", 32'(rx_byte), 1);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic cpu_write(input logic [7:0] b);
    @(negedge clk); cpu_wr = 1'b1; cpu_wdata = b;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(output logic [7:0] b);
    @(negedge clk); b = cpu_rdata; cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic tx_pull(output logic [7:0] b);
    @(negedge clk); tx_req = 1'b1;
    #1 b = tx_data;
    check("R9 tx strobe", 32'(tx_byte), 1);
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 rx_empty", 32'(rx_empty), 1);
    check("R1 tx_empty", 32'(tx_empty), 1);
    check("R1 full", 32'({rx_full, tx_full}), 0);
    check("R1 stretch", 32'(stretch), 0);
    check("R1 ovf", 32'(tx_ovf), 0);
    check("R1 rdata", 32'(cpu_rdata), 0);
  endtask

  task automatic t_rx_order;
    for (int i = 0; i < 8; i++) rx_push(8'h10 + 8'(i));
    @(negedge clk);
    check("R2 rx_full", 32'(rx_full), 1);
    check("R4 tx flags unaffected", 32'({tx_empty, tx_full}), 32'b10);
    for (int i = 0; i < 8; i++) begin
      cpu_read(got);
      check("R3 rx order", 32'(got), 32'(8'h10 + 8'(i)));
    end
    check("R3 rx_empty after drain", 32'(rx_empty), 1);
  endtask

  task automatic t_empty_read;
    cpu_read(got);
    check("R3 empty read data", 32'(got), 0);
    check("R3 empty stays", 32'(rx_empty), 1);
    rx_push(8'h77);
    rx_push(8'h78);
    cpu_read(got);
    check("R3 pointers unchanged", 32'(got), 32'h77);
    cpu_read(got);
    check("R3 second byte", 32'(got), 32'h78);
  endtask

  task automatic t_tx_order_ovf;
    for (int i = 0; i < 8; i++) cpu_write(8'hA0 + 8'(i));
    check("R4 tx_full", 32'(tx_full), 1);
    check("R4 rx flags unaffected", 32'({rx_empty, rx_full}), 32'b10);
    check("R5 ovf clear before", 32'(tx_ovf), 0);
    cpu_write(8'hEE);
    check("R5 ovf set", 32'(tx_ovf), 1);
    for (int i = 0; i < 8; i++) begin
      tx_pull(got);
      check("R4 tx order", 32'(got), 32'(8'hA0 + 8'(i)));
    end
    check("R5 dropped byte absent", 32'(tx_empty), 1);
    check("R5 ovf sticky", 32'(tx_ovf), 1);
  endtask

  task automatic t_rx_stretch;
    for (int i = 0; i < 8; i++) rx_push(8'h30 + 8'(i));
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'hAA;
    #1 check("R6 stretch on full", 32'(stretch), 1);
    check("R6 no strobe", 32'(rx_byte), 0);
    @(negedge clk);
    check("R6 still held", 32'({stretch, rx_byte}), 32'b10);
    cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0;
    #1 check("R8 rx release", 32'(stretch), 0);
    check("R8 rx strobe on release", 32'(rx_byte), 1);
    @(negedge clk); rx_valid = 1'b0;
    check("R8 held byte stored", 32'(rx_full), 1);
    for (int i = 1; i < 8; i++) begin
      cpu_read(got);
      check("R6 no overwrite", 32'(got), 32'(8'h30 + 8'(i)));
    end
    cpu_read(got);
    check("R8 held byte last", 32'(got), 32'hAA);
  endtask

  task automatic t_tx_stretch;
    @(negedge clk); tx_req = 1'b1;
    #1 check("R7 stretch on empty", 32'(stretch), 1);
    check("R7 no strobe", 32'(tx_byte), 0);
    @(negedge clk); cpu_wr = 1'b1; cpu_wdata = 8'h5C;
    #1 check("R7 still held", 32'(stretch), 1);
    @(negedge clk); cpu_wr = 1'b0;
    #1 check("R8 tx release", 32'(stretch), 0);
    check("R8 tx strobe", 32'(tx_byte), 1);
    check("R9 tx data", 32'(tx_data), 32'h5C);
    @(negedge clk); tx_req = 1'b0;
    check("R9 single move", 32'(tx_empty), 1);
  endtask

  task automatic t_flush;
    rx_push(8'h01);
    rx_push(8'h02);
    cpu_write(8'h03);
    @(negedge clk); flush = 1'b1; rx_valid = 1'b1; rx_data = 8'h44;
    #1 check("R10 no move during flush", 32'(rx_byte), 0);
    @(negedge clk); flush = 1'b0; rx_valid = 1'b0;
    check("R10 rx flushed", 32'(rx_empty), 1);
    check("R10 tx flushed", 32'(tx_empty), 1);
    check("R10 rdata zero", 32'(cpu_rdata), 0);
    check("R5 ovf survives flush", 32'(tx_ovf), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rx_order();
    t_empty_read();
    t_tx_order_ovf();
    t_rx_stretch();
    t_tx_stretch();
    t_flush();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 ovf cleared by reset", 32'(tx_ovf), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule